// File: doc/BRIEF.md
# Pending-to-Message Forwarding Engine

This block sits between the per-source interrupt pending logic and the fabric that carries message-signalled interrupts. For each source it keeps a pending bit, an enable bit and a 32-bit routing word. When a global forwarding switch is on and a source is both pending and enabled, the engine takes that source, clears its pending bit in the same clock edge, and presents one message on a valid/ready output. The message carries the destination hart index, the guest index and the identity number taken from the routing word.

Any accepted configuration write, and any new pending event, restarts a sweep over sources 1 to N in ascending order. Each source the sweep finds eligible is forwarded in turn. A separate software-generated message register sends one message at once, built from the written value with the guest index forced to zero.

The output holds one message at a time. While the message is not accepted, the sweep waits on the source it has reached. Deciding when a source becomes pending, and decoding bus addresses, are handled outside this block.

Top module: `fwd_engine`

## Requirements
- R1: While the forwarding switch (bit 0 of the domain word, kind code 0) is 0, no source message is emitted, and pending bits stay set until the switch is set to 1.
- R2: A source is forwarded only when its pending bit and its enable bit (bit 0 of kind code 1) are both 1. Forwarding clears its pending bit and leaves its enable bit unchanged. The message takes the hart index from bits 31:18 of the routing word, the guest index from bits 17:12 and the identity from bits 10:0.
- R3: A write to a routing word (kind code 2) stores only bits 31:18, 17:12 and 10:0. Bit 11 reads back as 0.
- R4: After every accepted write (kind codes 0 to 3), all sources 1 to N are examined again in ascending index order, and each eligible source is forwarded.
- R5: A write to the generate register (kind code 3) presents a message on the cycle after the write edge when the output is empty. The message takes its hart index from bits 31:18 and its identity from bits 10:0 of the written value, and its guest index is 0.
- R6: The generate register stores the written value with bits 17:12 cleared, and reads back that value.
- R7: At most one message is presented at a time. While msg_ready is low, msg_valid and the message fields hold steady, the sweep stalls, and every held-back message is delivered in order once msg_ready rises.
- R8: A pending event (pend_set bit i is source i+1) that arrives on the same edge as a sweep start for a source already pending produces exactly one message for that source.
- R9: Source index 0 and indexes above N are ignored on writes, and they read back as 0. Pending is read with kind code 4.
- R10: After reset, msg_valid is 0 and every stored word and bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for configuration |
| cfg_kind | input | 3 | Register kind: 0 domain, 1 enable, 2 routing, 3 generate |
| cfg_src | input | SRC_W | Source index of the write, 1..N |
| cfg_wdata | input | 32 | Write data |
| rd_kind | input | 3 | Readback kind: 0 to 3 as for writes, 4 pending |
| rd_src | input | SRC_W | Source index of the readback |
| rd_data | output | 32 | Combinational readback data |
| pend_set | input | NSRC | Pending events, bit i sets source i+1 |
| msg_valid | output | 1 | A message is presented |
| msg_ready | input | 1 | The sink accepts the presented message |
| msg_hart | output | 14 | Destination hart index |
| msg_guest | output | 6 | Destination guest index |
| msg_ident | output | 11 | Interrupt identity |

## Verification
Most internal faults show up at the message port within one sweep, which is at most N+2 cycles after the triggering write or event. A pending bit that fails to clear produces a second message for the same identity. A sweep pointer that is off by one shows up as messages in the wrong order, or as a source that is never forwarded. A broken stall path shows up as a changed field while msg_ready is low, within one cycle. Masking faults in the stored words show up at once on readback. A wrong guest field on a generated message is visible on the cycle after the write.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [2:0] {
    KIND_DOMAIN  = 3'd0,
    KIND_ENABLE  = 3'd1,
    KIND_ROUTE   = 3'd2,
    KIND_GENMSG  = 3'd3,
    KIND_PENDING = 3'd4
  } reg_kind_e;

  typedef struct packed {
    logic [13:0] hart;
    logic [5:0]  guest;
    logic [10:0] ident;
  } fwd_msg_t;

  localparam logic [31:0] ROUTE_KEEP  = 32'hFFFF_F7FF;
  localparam logic [31:0] GUEST_FIELD = 32'h0003_F000;

  function automatic logic [31:0] keep_route(input logic [31:0] v);
    return v & ROUTE_KEEP;
  endfunction

  function automatic logic [31:0] strip_guest(input logic [31:0] v);
    return v & ~GUEST_FIELD;
  endfunction

  function automatic fwd_msg_t route_to_msg(input logic [31:0] v);
    fwd_msg_t m;
    m.hart  = v[31:18];
    m.guest = v[17:12];
    m.ident = v[10:0];
    return m;
  endfunction

  function automatic fwd_msg_t gen_to_msg(input logic [31:0] v);
    fwd_msg_t m;
    m.hart  = v[31:18];
    m.guest = 6'd0;
    m.ident = v[10:0];
    return m;
  endfunction

endpackage

// File: rtl/fwd_src_bank.sv
module fwd_src_bank #(
  parameter int NSRC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      en_we,
  input  logic [NSRC-1:0]      route_we,
  input  logic [31:0]          wdata,
  input  logic [NSRC-1:0]      pend_set,
  input  logic [NSRC-1:0]      pend_clr,
  output logic [NSRC-1:0]      pend_q,
  output logic [NSRC-1:0]      en_q,
  output logic [NSRC-1:0][31:0] route_q
);
  import fwd_pkg::*;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic        p_r;
    logic        e_r;
    logic [31:0] t_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_r <= 1'b0;
        e_r <= 1'b0;
        t_r <= '0;
      end else begin
        // a clear on the same edge as a new event absorbs the event
        p_r <= (p_r | pend_set[g]) & ~pend_clr[g];
        if (en_we[g])    e_r <= wdata[0];
        if (route_we[g]) t_r <= keep_route(wdata);
      end
    end

    assign pend_q[g]  = p_r;
    assign en_q[g]    = e_r;
    assign route_q[g] = t_r;
  end

endmodule

// File: rtl/fwd_scan.sv
module fwd_scan #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             fwd_on,
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  en,
  input  logic             slot_free,
  input  logic             hold,
  output logic             fire,
  output logic [IDX_W-1:0] fire_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NSRC - 1);

  logic             active_q;
  logic [IDX_W-1:0] ptr_q;
  logic             elig;
  logic             advance;

  assign elig     = active_q && fwd_on && pend[ptr_q] && en[ptr_q];
  assign fire     = elig && slot_free && !hold;
  assign advance  = active_q && (!elig || fire);
  assign fire_idx = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else if (restart) begin
      active_q <= 1'b1;
      ptr_q    <= '0;
    end else if (advance) begin
      if (ptr_q == LAST) active_q <= 1'b0;
      else               ptr_q    <= ptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/fwd_msg_slot.sv
module fwd_msg_slot (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  fwd_pkg::fwd_msg_t  load_msg,
  input  logic               ready,
  output logic               valid,
  output fwd_pkg::fwd_msg_t  msg,
  output logic               free
);
  assign free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      msg   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      msg   <= load_msg;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fwd_engine.sv
module fwd_engine #(
  parameter int NSRC = 8,
  localparam int SRC_W = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_kind,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [31:0]      cfg_wdata,
  input  logic [2:0]       rd_kind,
  input  logic [SRC_W-1:0] rd_src,
  output logic [31:0]      rd_data,
  input  logic [NSRC-1:0]  pend_set,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [13:0]      msg_hart,
  output logic [5:0]       msg_guest,
  output logic [10:0]      msg_ident
);
  import fwd_pkg::*;

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

  // ---------------- write decode ----------------
  reg_kind_e        wkind;
  logic             wr_ok;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_acc;
  logic             wr_dom, wr_gen;
  logic [NSRC-1:0]  en_we, route_we;

  assign wkind  = reg_kind_e'(cfg_kind);
  assign wr_ok  = (cfg_src != '0) && (int'(cfg_src) <= NSRC);
  assign wr_idx = IDX_W'(cfg_src - 1'b1);
  assign wr_acc = cfg_we && (cfg_kind <= 3'd3);
  assign wr_dom = cfg_we && (wkind == KIND_DOMAIN);
  assign wr_gen = cfg_we && (wkind == KIND_GENMSG);
  assign en_we    = (cfg_we && wkind == KIND_ENABLE && wr_ok) ? (ONE << wr_idx) : '0;
  assign route_we = (cfg_we && wkind == KIND_ROUTE  && wr_ok) ? (ONE << wr_idx) : '0;

  // ---------------- domain and generate state ----------------
  logic        ie_q;
  logic [31:0] genmsi_q;
  logic        gen_req_q;
  logic        gen_take;
  logic        slot_free;

  assign gen_take = (gen_req_q || wr_gen) && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q      <= 1'b0;
      genmsi_q  <= '0;
      gen_req_q <= 1'b0;
    end else begin
      if (wr_dom) ie_q     <= cfg_wdata[0];
      if (wr_gen) genmsi_q <= strip_guest(cfg_wdata);
      gen_req_q <= (gen_req_q || wr_gen) && !gen_take;
    end
  end

  // ---------------- per-source state ----------------
  logic [NSRC-1:0]       pend_q, en_q, pend_clr;
  logic [NSRC-1:0][31:0] route_q;
  logic                  scan_fire;
  logic [IDX_W-1:0]      fire_idx;
  logic                  restart;

  assign restart  = wr_acc || (|pend_set);
  assign pend_clr = scan_fire ? (ONE << fire_idx) : '0;

  fwd_src_bank #(.NSRC(NSRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (en_we),
    .route_we (route_we),
    .wdata    (cfg_wdata),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .pend_q   (pend_q),
    .en_q     (en_q),
    .route_q  (route_q)
  );

  fwd_scan #(.NSRC(NSRC), .IDX_W(IDX_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .fwd_on    (ie_q),
    .pend      (pend_q),
    .en        (en_q),
    .slot_free (slot_free),
    .hold      (gen_take),
    .fire      (scan_fire),
    .fire_idx  (fire_idx)
  );

  // ---------------- output slot ----------------
  fwd_msg_t load_msg, out_msg;
  logic     load;

  assign load     = gen_take || scan_fire;
  assign load_msg = gen_take ? gen_to_msg(wr_gen ? cfg_wdata : genmsi_q)
                             : route_to_msg(route_q[fire_idx]);

  fwd_msg_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_msg (load_msg),
    .ready    (msg_ready),
    .valid    (msg_valid),
    .msg      (out_msg),
    .free     (slot_free)
  );

  assign msg_hart  = out_msg.hart;
  assign msg_guest = out_msg.guest;
  assign msg_ident = out_msg.ident;

  // ---------------- readback ----------------
  logic             rd_ok;
  logic [IDX_W-1:0] rd_idx;

  assign rd_ok  = (rd_src != '0) && (int'(rd_src) <= NSRC);
  assign rd_idx = IDX_W'(rd_src - 1'b1);

  always_comb begin
    rd_data = '0;
    case (rd_kind)
      3'd0: rd_data = {31'd0, ie_q};
      3'd1: if (rd_ok) rd_data = {31'd0, en_q[rd_idx]};
      3'd2: if (rd_ok) rd_data = route_q[rd_idx];
      3'd3: rd_data = genmsi_q;
      3'd4: if (rd_ok) rd_data = {31'd0, pend_q[rd_idx]};
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/fwd_engine_chk.sv
module fwd_engine_chk #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [13:0]      msg_hart,
  input logic [5:0]       msg_guest,
  input logic [10:0]      msg_ident,
  input logic             ie_q,
  input logic             scan_fire,
  input logic             gen_take,
  input logic             cfg_we,
  input logic [IDX_W-1:0] fire_idx,
  input logic [NSRC-1:0]  pend_q,
  input logic [NSRC-1:0]  en_q
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_hart) &&
                                   $stable(msg_guest) && $stable(msg_ident)));

  assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gen_take, scan_fire}));

  assert_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !scan_fire);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_fire |=> !pend_q[$past(fire_idx)]);

  assert_enable_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_fire && !cfg_we) |=> $stable(en_q));

  assert_guest_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gen_take |=> (msg_valid && msg_guest == 6'd0));

endmodule

bind fwd_engine fwd_engine_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_hart  (msg_hart),
  .msg_guest (msg_guest),
  .msg_ident (msg_ident),
  .ie_q      (ie_q),
  .scan_fire (scan_fire),
  .gen_take  (gen_take),
  .cfg_we    (cfg_we),
  .fire_idx  (fire_idx),
  .pend_q    (pend_q),
  .en_q      (en_q)
);

// File: tb/fwd_engine_bench.sv
module fwd_engine_bench;
  localparam int NSRC  = 8;
  localparam int SRC_W = $clog2(NSRC + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_kind = '0;
  logic [SRC_W-1:0] cfg_src = '0;
  logic [31:0]      cfg_wdata = '0;
  logic [2:0]       rd_kind = '0;
  logic [SRC_W-1:0] rd_src = '0;
  logic [31:0]      rd_data;
  logic [NSRC-1:0]  pend_set = '0;
  logic             msg_valid;
  logic             msg_ready = 1'b1;
  logic [13:0]      msg_hart;
  logic [5:0]       msg_guest;
  logic [10:0]      msg_ident;

  always #10 clk = ~clk;  // 50 MHz

  fwd_engine #(.NSRC(NSRC)) u_fwd_engine (.*);

  int n_run  = 0;
  int n_fail = 0;
  int n_got  = 0;
  logic [13:0] got_hart  [256];
  logic [5:0]  got_guest [256];
  logic [10:0] got_ident [256];

  // record accepted messages away from the active edge
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && n_got < 256) begin
      got_hart[n_got]  = msg_hart;
      got_guest[n_got] = msg_guest;
      got_ident[n_got] = msg_ident;
      n_got++;
    end
  end

  function automatic logic [31:0] mk_route(input int s);
    return {14'(s + 100), 6'(s), 1'b0, 11'(16 + s)};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] k, input int s, input logic [31:0] d);
    step(1);
    cfg_we = 1'b1; cfg_kind = k; cfg_src = SRC_W'(s); cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] k, input int s, output logic [31:0] d);
    rd_kind = k; rd_src = SRC_W'(s);
    #1;
    d = rd_data;
  endtask

  task automatic pulse(input logic [NSRC-1:0] v);
    step(1);
    pend_set = v;
    step(1);
    pend_set = '0;
  endtask

  task automatic expect_msg(input int k, input int s, input string req);
    logic [31:0] r;
    r = mk_route(s);
    chk(req, "hart", 32'(got_hart[k]), 32'(r[31:18]));
    chk(req, "guest", 32'(got_guest[k]), 32'(r[17:12]));
    chk(req, "ident", 32'(got_ident[k]), 32'(r[10:0]));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    chk("R10", "msg_valid", 32'(msg_valid), 0);
    rd(3'd0, 0, d); chk("R10", "domain", d, 0);
    rd(3'd1, 3, d); chk("R10", "enable", d, 0);
    rd(3'd2, 5, d); chk("R10", "route", d, 0);
    rd(3'd3, 0, d); chk("R10", "genmsg", d, 0);
  endtask

  task automatic t_route_mask;
    logic [31:0] d;
    wr(3'd2, 2, 32'hFFFF_FFFF);
    rd(3'd2, 2, d); chk("R3", "route mask", d, 32'hFFFF_F7FF);
    wr(3'd2, 0, 32'hFFFF_FFFF);
    rd(3'd2, 0, d); chk("R9", "route src0", d, 0);
    wr(3'd2, NSRC + 1, 32'h1234_5678);
    rd(3'd2, NSRC + 1, d); chk("R9", "route src N+1", d, 0);
    rd(3'd2, 1, d); chk("R9", "route src1 untouched", d, 0);
    wr(3'd1, 0, 32'h1);
    rd(3'd1, 0, d); chk("R9", "enable src0", d, 0);
  endtask

  task automatic t_gating;
    logic [31:0] d;
    int base;
    base = n_got;
    wr(3'd1, 3, 32'h1);
    wr(3'd2, 3, mk_route(3));
    pulse(NSRC'(1) << 2);
    step(20);
    chk("R1", "no message while off", 32'(n_got - base), 0);
    rd(3'd4, 3, d); chk("R1", "pending held", d, 1);
    wr(3'd0, 0, 32'h1);
    step(20);
    chk("R1", "one message after on", 32'(n_got - base), 1);
    expect_msg(base, 3, "R2");
    rd(3'd4, 3, d); chk("R2", "pending cleared", d, 0);
    rd(3'd1, 3, d); chk("R2", "enable kept", d, 1);
  endtask

  task automatic t_order;
    logic [31:0] d;
    int base;
    wr(3'd0, 0, 32'h0);
    for (int s = 2; s <= 7; s += 5) begin
      wr(3'd1, s, 32'h1);
      wr(3'd2, s, mk_route(s));
    end
    wr(3'd1, 5, 32'h1);
    wr(3'd2, 5, mk_route(5));
    base = n_got;
    pulse(8'b0100_1010);  // sources 7, 4, 2
    pulse(8'b0001_0000);  // source 5
    step(10);
    chk("R1", "held while off", 32'(n_got - base), 0);
    wr(3'd0, 0, 32'h1);
    step(30);
    chk("R4", "count", 32'(n_got - base), 3);
    expect_msg(base,     2, "R4");
    expect_msg(base + 1, 5, "R4");
    expect_msg(base + 2, 7, "R4");
    rd(3'd4, 4, d); chk("R2", "disabled stays pending", d, 1);
  endtask

  task automatic t_rescan;
    int base;
    base = n_got;
    wr(3'd2, 4, mk_route(4));
    step(20);
    chk("R2", "disabled not forwarded", 32'(n_got - base), 0);
    wr(3'd1, 4, 32'h1);
    step(20);
    chk("R4", "enable write rescans", 32'(n_got - base), 1);
    expect_msg(base, 4, "R4");
  endtask

  task automatic t_stall;
    int base;
    logic [10:0] held;
    int bad;
    base = n_got;
    msg_ready = 1'b0;
    pulse(8'b0101_0010);  // sources 7, 5, 2
    step(4);
    @(negedge clk);
    chk("R7", "valid while stalled", 32'(msg_valid), 1);
    chk("R7", "first held ident", 32'(msg_ident), 32'(mk_route(2) & 32'h7FF));
    held = msg_ident;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!msg_valid || msg_ident != held) bad++;
    end
    chk("R7", "stable cycles broken", 32'(bad), 0);
    step(1);
    msg_ready = 1'b1;
    step(20);
    chk("R7", "all delivered", 32'(n_got - base), 3);
    expect_msg(base,     2, "R7");
    expect_msg(base + 1, 5, "R7");
    expect_msg(base + 2, 7, "R7");
  endtask

  task automatic t_generate;
    logic [31:0] d;
    int base;
    base = n_got;
    wr(3'd3, 0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R5", "valid next cycle", 32'(msg_valid), 1);
    chk("R5", "hart", 32'(msg_hart), 32'h3FFF);
    chk("R5", "guest zero", 32'(msg_guest), 0);
    chk("R5", "ident", 32'(msg_ident), 32'h7FF);
    step(10);
    chk("R5", "one message", 32'(n_got - base), 1);
    rd(3'd3, 0, d); chk("R6", "readback", d, 32'hFFFC_0FFF);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    int base;
    wr(3'd0, 0, 32'h0);
    wr(3'd1, 6, 32'h1);
    wr(3'd2, 6, mk_route(6));
    pulse(NSRC'(1) << 5);
    base = n_got;
    step(1);
    cfg_we = 1'b1; cfg_kind = 3'd0; cfg_src = '0; cfg_wdata = 32'h1;
    pend_set = NSRC'(1) << 5;
    step(1);
    cfg_we = 1'b0; pend_set = '0;
    step(20);
    chk("R8", "single message", 32'(n_got - base), 1);
    expect_msg(base, 6, "R8");
    rd(3'd4, 6, d); chk("R8", "pending cleared", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_route_mask();
    t_gating();
    t_order();
    t_rescan();
    t_stall();
    t_generate();
    t_collide();
    step(5);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule